// File: doc/BRIEF.md
# JTAG Clock Ratio Measurement Counter

This block adds one data register to a JTAG test access port. With it an external debugger can estimate the frequency of the chip's internal system clock. The debugger shifts a 16-bit start value into the register on TCK. At the update strobe that value is passed to the system clock domain. There a down-counter loads it and decrements once per system clock until it reaches zero. A busy flag stays high while the countdown is running. The debugger polls it through later data-register scans, and the first bit shifted out is the busy flag. The debugger times how long busy stays high and divides the start value by that time to estimate the internal clock rate.

The TAP state machine is not part of this block. Its Capture-DR, Shift-DR and Update-DR states appear as three strobes sampled on the TCK rising edge, together with the current instruction-register code. The load request crosses to the system domain as a toggle through a synchronizer. The load value stays stable in the TCK domain until the countdown has finished. Completion comes back as a toggle through a two-flop synchronizer, and busy is the mismatch between the request toggle and the returned toggle. As a result, busy is high in the TCK domain from the update edge onward and never reads a false idle.

A start scan must shift all 16 bits. A shorter scan leaves a load value that is not defined.

Top module: `jtag_clkratio_dr`

## Requirements
- R1: The strobes act only while the instruction code equals 5'b10111 (0x17). With any other code, capture, shift and update leave the shift register and the busy state unchanged.
- R2: Shift-DR moves the 16-bit register one place toward bit 0. The `tdi` bit enters at bit 15, and `tdo` always shows bit 0. Data therefore enters and leaves least-significant bit first.
- R3: Capture-DR loads the register with busy in bit 0 and zeros in bits 15..1. The first bit shifted out is therefore the busy flag.
- R4: An update while idle copies the register into the load value and raises busy at the same TCK edge. A capture at the very next TCK edge reads busy as 1.
- R5: For a nonzero start value N, the system-domain counter decrements once per system clock. Busy stays high for at least N system clock periods after the update. It reads low within N system periods plus a few cycles of synchronizer latency.
- R6: A start value of zero performs no countdown. Busy clears within the synchronizer latency.
- R7: An update that arrives while busy is high is ignored. The running countdown and its load value are kept, and a fresh start is accepted once busy has cleared.
- R8: After reset, `tdo` is 0 and busy reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock |
| tck_rst_n | input | 1 | Active-low asynchronous reset, TCK domain |
| sys_clk | input | 1 | Internal system clock that is being measured |
| sys_rst_n | input | 1 | Active-low asynchronous reset, system domain |
| ir_code | input | 5 | Current instruction-register code |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the register |

## Verification
Capture, shift and update take effect at the TCK rising edge that samples them. The bench drives strobes on falling edges and reads `tdo` on the following falling edge, so a capture just after an update shows busy one TCK later. Countdown completion reaches the TCK domain after about three system clocks to start, N system clocks of counting, and two TCK cycles of synchronization. Each timing check therefore reads busy at one point that is safely before N system periods and at another point that is safely after N periods plus that latency. A zero start value is read back after six TCK cycles.

// File: rtl/jcr_pkg.sv
package jcr_pkg;
   localparam int           JCR_IR_W      = 5;
   localparam logic [4:0]   JCR_RATIO_OP  = 5'h17;
   localparam int           JCR_DR_W      = 16;
   localparam int           JCR_SYNC_MIN  = 2;
endpackage

// File: rtl/jcr_sync.sv
module jcr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < jcr_pkg::JCR_SYNC_MIN) begin : g_bad_stages
         $error("jcr_sync: STAGES below minimum");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/jcr_tck_side.sv
module jcr_tck_side #(
   parameter int   DR_W = jcr_pkg::JCR_DR_W
) (
   input  logic            tck,
   input  logic            rst_n,
   input  logic            sel,
   input  logic            capture_dr,
   input  logic            shift_dr,
   input  logic            update_dr,
   input  logic            tdi,
   input  logic            done_tog_s,
   output logic            tdo,
   output logic            start_tog,
   output logic [DR_W-1:0] load_val,
   output logic            busy
);
   localparam int PAD_W = DR_W - 1;

   logic [DR_W-1:0] shreg;

   assign busy = start_tog ^ done_tog_s;
   assign tdo  = shreg[0];

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         load_val  <= '0;
         start_tog <= 1'b0;
      end else if (sel) begin
         if (capture_dr)
            shreg <= {{PAD_W{1'b0}}, busy};
         else if (shift_dr)
            shreg <= {tdi, shreg[DR_W-1:1]};
         if (update_dr && !busy) begin
            load_val  <= shreg;
            start_tog <= ~start_tog;
         end
      end
   end
endmodule

// File: rtl/jcr_sys_counter.sv
module jcr_sys_counter #(
   parameter int CNT_W = jcr_pkg::JCR_DR_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_tog_s,
   input  logic [CNT_W-1:0] load_val,
   output logic             done_tog,
   output logic             load,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic start_seen;

   assign load = start_tog_s ^ start_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_seen <= 1'b0;
         done_tog   <= 1'b0;
         cnt        <= '0;
      end else begin
         start_seen <= start_tog_s;
         if (load) begin
            cnt <= load_val;
            if (load_val == '0)
               done_tog <= ~done_tog;
         end else if (cnt != '0) begin
            cnt <= cnt - ONE;
            if (cnt == ONE)
               done_tog <= ~done_tog;
         end
      end
   end
endmodule

// File: rtl/jtag_clkratio_dr.sv
module jtag_clkratio_dr #(
   parameter int                     IR_W        = jcr_pkg::JCR_IR_W,
   parameter logic [IR_W-1:0]        IR_CODE     = jcr_pkg::JCR_RATIO_OP,
   parameter int                     DR_W        = jcr_pkg::JCR_DR_W,
   parameter int                     SYNC_STAGES = 2
) (
   input  logic            tck,
   input  logic            tck_rst_n,
   input  logic            sys_clk,
   input  logic            sys_rst_n,
   input  logic [IR_W-1:0] ir_code,
   input  logic            capture_dr,
   input  logic            shift_dr,
   input  logic            update_dr,
   input  logic            tdi,
   output logic            tdo
);
   generate
      if (DR_W < 2) begin : g_bad_dr
         $error("jtag_clkratio_dr: DR_W must be at least 2");
      end
      if (IR_W < 1) begin : g_bad_ir
         $error("jtag_clkratio_dr: IR_W must be positive");
      end
   endgenerate

   logic            sel;
   logic            start_tog, start_tog_s;
   logic            done_tog, done_tog_s;
   logic            busy_tck;
   logic            load;
   logic [DR_W-1:0] load_val;
   logic [DR_W-1:0] cnt;

   assign sel = (ir_code == IR_CODE);

   jcr_tck_side #(.DR_W(DR_W)) u_tck (
      .tck(tck), .rst_n(tck_rst_n), .sel(sel),
      .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
      .tdi(tdi), .done_tog_s(done_tog_s), .tdo(tdo),
      .start_tog(start_tog), .load_val(load_val), .busy(busy_tck)
   );

   jcr_sync #(.STAGES(SYNC_STAGES)) u_sync_start (
      .clk(sys_clk), .rst_n(sys_rst_n), .d(start_tog), .q(start_tog_s)
   );

   jcr_sync #(.STAGES(SYNC_STAGES)) u_sync_done (
      .clk(tck), .rst_n(tck_rst_n), .d(done_tog), .q(done_tog_s)
   );

   jcr_sys_counter #(.CNT_W(DR_W)) u_cnt (
      .clk(sys_clk), .rst_n(sys_rst_n), .start_tog_s(start_tog_s),
      .load_val(load_val), .done_tog(done_tog), .load(load), .cnt(cnt)
   );
endmodule

// File: rtl/jcr_checker.sv
module jcr_checker #(
   parameter int DR_W = 16
) (
   input logic            tck,
   input logic            tck_rst_n,
   input logic            sys_clk,
   input logic            sys_rst_n,
   input logic            sel,
   input logic            capture_dr,
   input logic            update_dr,
   input logic            tdo,
   input logic            busy_tck,
   input logic [DR_W-1:0] load_val,
   input logic [DR_W-1:0] cnt,
   input logic            load
);
   a_r1_unselected_no_start: assert property (@(posedge tck) disable iff (!tck_rst_n)
      (!busy_tck && !(update_dr && sel)) |=> !busy_tck);

   a_r3_capture_busy_lsb: assert property (@(posedge tck) disable iff (!tck_rst_n)
      (capture_dr && sel) |=> (tdo == $past(busy_tck)));

   a_r4_busy_on_update: assert property (@(posedge tck) disable iff (!tck_rst_n)
      (update_dr && sel && !busy_tck) |=> busy_tck);

   a_r7_hold_load_val: assert property (@(posedge tck) disable iff (!tck_rst_n)
      busy_tck |=> $stable(load_val));

   a_r5_count_step: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      (cnt != '0 && !load) |=> (cnt == DR_W'($past(cnt) - DR_W'(1))));

   a_r6_zero_no_count: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      (load && load_val == '0) |=> (cnt == '0));
endmodule

bind jtag_clkratio_dr jcr_checker #(.DR_W(DR_W)) u_chk (
   .tck(tck), .tck_rst_n(tck_rst_n), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
   .sel(sel), .capture_dr(capture_dr), .update_dr(update_dr), .tdo(tdo),
   .busy_tck(busy_tck), .load_val(load_val), .cnt(cnt), .load(load)
);

// File: tb/jtag_clkratio_dr_tb.sv
module jtag_clkratio_dr_tb;
   localparam int TCK_PERIOD = 20;
   localparam int SYS_PERIOD = 6;
   localparam logic [4:0] OP_RATIO = 5'h17;
   localparam logic [4:0] OP_OTHER = 5'h0C;

   logic tck = 0, sys_clk = 0;
   logic tck_rst_n = 0, sys_rst_n = 0;
   logic [4:0] ir_code = OP_RATIO;
   logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
   logic tdo;
   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #(TCK_PERIOD/2) tck = ~tck;
   always #(SYS_PERIOD/2) sys_clk = ~sys_clk;

   jtag_clkratio_dr u_dut (
      .tck(tck), .tck_rst_n(tck_rst_n), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
      .ir_code(ir_code), .capture_dr(capture_dr), .shift_dr(shift_dr),
      .update_dr(update_dr), .tdi(tdi), .tdo(tdo)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_tck(input int n);
      for (int i = 0; i < n; i++) @(negedge tck);
   endtask

   task automatic scan16(input logic [15:0] din, output logic [15:0] dout);
      for (int i = 0; i < 16; i++) begin
         @(negedge tck);
         dout[i] = tdo;
         tdi = din[i];
         shift_dr = 1;
      end
      @(negedge tck);
      shift_dr = 0;
   endtask

   task automatic read_busy(output logic b);
      @(negedge tck); capture_dr = 1;
      @(negedge tck); capture_dr = 0;
      b = tdo;
   endtask

   task automatic start(input logic [15:0] val);
      logic [15:0] junk;
      scan16(val, junk);
      @(negedge tck); update_dr = 1;
      @(negedge tck); update_dr = 0;
   endtask

   task automatic t_reset;
      logic b;
      check("R8 tdo after reset", {15'b0, tdo}, 16'h0);
      read_busy(b);
      check("R8 busy after reset", {15'b0, b}, 16'h0);
   endtask

   task automatic t_shift_echo;
      logic [15:0] o;
      scan16(16'hA5C3, o);
      scan16(16'h0000, o);
      check("R2 shift echo", o, 16'hA5C3);
      scan16(16'h1E0F, o);
      scan16(16'hFFFF, o);
      check("R2 shift echo 2", o, 16'h1E0F);
   endtask

   task automatic t_unselected;
      logic [15:0] o;
      logic b;
      scan16(16'h3C5A, o);
      ir_code = OP_OTHER;
      scan16(16'hFFFF, o);
      @(negedge tck); capture_dr = 1;
      @(negedge tck); capture_dr = 0; update_dr = 1;
      @(negedge tck); update_dr = 0;
      ir_code = OP_RATIO;
      scan16(16'h0000, o);
      check("R1 register kept when unselected", o, 16'h3C5A);
      read_busy(b);
      check("R1 no start when unselected", {15'b0, b}, 16'h0);
   endtask

   task automatic t_capture_idle;
      logic [15:0] o;
      @(negedge tck); capture_dr = 1;
      @(negedge tck); capture_dr = 0;
      scan16(16'hFFFF, o);
      check("R3 capture idle word", o, 16'h0000);
   endtask

   task automatic t_count_1000;
      logic b;
      logic [15:0] o;
      start(16'd1000);
      read_busy(b);
      check("R4 busy right after update", {15'b0, b}, 16'h1);
      @(negedge tck); capture_dr = 1;
      @(negedge tck); capture_dr = 0;
      scan16(16'h0000, o);
      check("R3 capture busy word", o, 16'h0001);
      wait_tck(262);
      read_busy(b);
      check("R5 still busy before N sys cycles", {15'b0, b}, 16'h1);
      wait_tck(40);
      read_busy(b);
      check("R5 idle after N sys cycles", {15'b0, b}, 16'h0);
   endtask

   task automatic t_count_300;
      logic b;
      start(16'd300);
      wait_tck(80);
      read_busy(b);
      check("R5 N=300 busy", {15'b0, b}, 16'h1);
      wait_tck(20);
      read_busy(b);
      check("R5 N=300 done", {15'b0, b}, 16'h0);
   endtask

   task automatic t_zero;
      logic b;
      start(16'd0);
      wait_tck(6);
      read_busy(b);
      check("R6 zero start clears", {15'b0, b}, 16'h0);
   endtask

   task automatic t_ignore_busy;
      logic b;
      start(16'd1000);
      start(16'd5);
      wait_tck(200);
      read_busy(b);
      check("R7 update while busy ignored", {15'b0, b}, 16'h1);
      wait_tck(110);
      read_busy(b);
      check("R7 original countdown ends", {15'b0, b}, 16'h0);
      start(16'd5);
      read_busy(b);
      check("R7 fresh start accepted", {15'b0, b}, 16'h1);
      wait_tck(8);
      read_busy(b);
      check("R7 short countdown ends", {15'b0, b}, 16'h0);
   endtask

   task automatic t_full_range;
      logic b;
      start(16'hFFFF);
      wait_tck(19500);
      read_busy(b);
      check("R5 max value busy", {15'b0, b}, 16'h1);
      wait_tck(220);
      read_busy(b);
      check("R5 max value done", {15'b0, b}, 16'h0);
   endtask

   initial begin
      wait_tck(3);
      tck_rst_n = 1;
      sys_rst_n = 1;
      t_reset();
      t_shift_echo();
      t_unselected();
      t_capture_idle();
      t_count_1000();
      t_count_300();
      t_zero();
      t_ignore_busy();
      t_full_range();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(TCK_PERIOD * 60000);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule